// File: doc/BRIEF.md
# Enabled Serial Pattern Detector

This block is a clocked finite state machine that watches a one-bit serial stream and flags the cycle in which a fixed bit pattern has been fully received. The pattern and its length are parameters. The pattern is taken first bit first, and the most significant bit of the `PATTERN` parameter is the first bit expected. The default configuration looks for `1011`. A seven-bit configuration looks for `1010011`.

The stream enters as a one-bit valid/data pair. A bit is consumed only in a cycle where `in_valid` is high at the rising clock edge. There is no ready signal, because the detector accepts a bit in every cycle and never applies back-pressure. A producer may therefore present valid bits back to back, or leave gaps of any length. `hit` is a Mealy output that depends on the current inputs. When a partial match breaks, the machine falls back to the longest pattern prefix that is still a suffix of the bits seen since the last restart. After a full match it restarts from nothing, so the bits of one match never count toward the next.

Top module: `bitseq_spotter`

## Requirements
- R1: With the default parameters (`PATTERN` = 4'b1011, first bit = MSB), `hit` is 1 in the cycle where the fourth bit of 1,0,1,1 is presented with `in_valid` high. It is 1 for that single cycle only.
- R2: With `PAT_LEN` = 7 and `PATTERN` = 7'b1010011, `hit` rises in the cycle where the final bit of 1,0,1,0,0,1,1 is presented with `in_valid` high.
- R3: Detection is non-overlapping. After a hit the machine returns to the empty state. For example, the valid stream 1,0,1,1,0,1,1 gives exactly one hit with the default pattern.
- R4: In a cycle where `in_valid` is 0, `in_bit` is ignored and the matching progress is held. Invalid cycles inserted anywhere inside a pattern do not change when, or whether, the hit occurs.
- R5: `hit` is 0 in every cycle where `in_valid` is 0.
- R6: `rst_n` is an active-low synchronous reset. It discards any partial match, and `hit` is held at 0 while `rst_n` is 0.
- R7: On a mismatch, the machine keeps the longest pattern prefix that is a suffix of the bits received since the last restart. For example, 1,0,1,0,1,1 hits on its last bit.
- R8: For any stream of `in_valid` and `in_bit`, the output equals that of a model which appends each valid bit to a history and reports a hit when the history ends in the pattern, then clears the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_bit`; 1 means the bit is consumed this cycle |
| in_bit | input | 1 | Serial data bit |
| hit | output | 1 | 1 in the cycle the final pattern bit is accepted |

## Verification
A corrupted match count appears at the ports only when a bit stream reaches the point where that count decides the outcome. A hit then arrives early, arrives late, or goes missing, and this can show up as late as one pattern length of valid bits after the fault. The reference model therefore compares `hit` on every cycle over long random streams with gaps in `in_valid`. Directed sequences target the cases where a wrong state would diverge soonest: overlap candidates, mismatch fallbacks, enable gaps placed mid-pattern, and a reset in the middle of a match.

// File: rtl/bitseq_pkg.sv
package bitseq_pkg;
  localparam int MAX_LEN = 32;

  // Matched-prefix length after appending bit b to a state that has
  // already matched s pattern bits. A complete match yields 0 (restart).
  function automatic int advance(logic [MAX_LEN-1:0] pat, int len, int s, logic b);
    int best;
    logic ok;
    logic c;
    best = 0;
    for (int k = 1; k <= MAX_LEN; k++) begin
      if (k <= s + 1) begin
        ok = 1'b1;
        for (int j = 0; j < MAX_LEN; j++) begin
          if (j < k) begin
            c = ((s + 1 - k + j) < s) ? pat[len - 1 - (s + 1 - k + j)] : b;
            if (c != pat[len - 1 - j]) ok = 1'b0;
          end
        end
        if (ok) best = k;
      end
    end
    if (best >= len) best = 0;
    return best;
  endfunction
endpackage

// File: rtl/bitseq_step_table.sv
module bitseq_step_table #(
  parameter int PAT_LEN = 4,
  parameter logic [PAT_LEN-1:0] PATTERN = 4'b1011,
  parameter int SW = $clog2(PAT_LEN)
) (
  input  logic [SW-1:0] cur,
  input  logic          bit_in,
  output logic [SW-1:0] nxt
);
  localparam int SLOTS = 2 ** SW;
  localparam logic [bitseq_pkg::MAX_LEN-1:0] PAT_W = bitseq_pkg::MAX_LEN'(PATTERN);

  logic [SW-1:0] on_zero [SLOTS];
  logic [SW-1:0] on_one  [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    if (s < PAT_LEN) begin : g_live
      localparam int N0 = bitseq_pkg::advance(PAT_W, PAT_LEN, s, 1'b0);
      localparam int N1 = bitseq_pkg::advance(PAT_W, PAT_LEN, s, 1'b1);
      assign on_zero[s] = SW'(N0);
      assign on_one[s]  = SW'(N1);
    end else begin : g_unused
      assign on_zero[s] = '0;
      assign on_one[s]  = '0;
    end
  end

  assign nxt = bit_in ? on_one[cur] : on_zero[cur];
endmodule

// File: rtl/bitseq_state_reg.sv
module bitseq_state_reg #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [SW-1:0] nxt,
  output logic [SW-1:0] state
);
  always_ff @(posedge clk) begin
    if (!rst_n)   state <= '0;
    else if (adv) state <= nxt;
  end

  // R4: no consumed bit, no movement
  p_hold_when_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(state));
  // R6: a reset cycle leaves the machine empty
  p_reset_empties_r6: assert property (@(posedge clk)
    !rst_n |=> state == '0);
endmodule

// File: rtl/bitseq_hit_logic.sv
module bitseq_hit_logic #(
  parameter int PAT_LEN = 4,
  parameter logic [PAT_LEN-1:0] PATTERN = 4'b1011,
  parameter int SW = $clog2(PAT_LEN)
) (
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_bit,
  input  logic [SW-1:0] state,
  output logic          hit
);
  localparam logic [SW-1:0] LAST = SW'(PAT_LEN - 1);
  always_comb hit = rst_n && in_valid && (state == LAST) && (in_bit == PATTERN[0]);
endmodule

// File: rtl/bitseq_spotter.sv
module bitseq_spotter #(
  parameter int PAT_LEN = 4,
  parameter logic [PAT_LEN-1:0] PATTERN = 4'b1011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic hit
);
  localparam int SW = $clog2(PAT_LEN);
  localparam logic [SW-1:0] LAST = SW'(PAT_LEN - 1);

  logic [SW-1:0] state;
  logic [SW-1:0] nxt;

  bitseq_step_table #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .SW(SW)) u_table (
    .cur(state), .bit_in(in_bit), .nxt(nxt));

  bitseq_state_reg #(.SW(SW)) u_state (
    .clk(clk), .rst_n(rst_n), .adv(in_valid), .nxt(nxt), .state(state));

  bitseq_hit_logic #(.PAT_LEN(PAT_LEN), .PATTERN(PATTERN), .SW(SW)) u_hit (
    .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .state(state), .hit(hit));

  // R5: output silent on invalid cycles
  p_hit_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> in_valid);
  // R3: restart from nothing after every hit
  p_restart_after_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> state == '0);
  // R1: a hit only ever completes the last pattern position
  p_hit_from_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> state == LAST);
  // R7: matched length stays within the pattern
  p_state_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state <= LAST);
endmodule

// File: tb/sim_bitseq_spotter.sv
module sim_bitseq_spotter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic hit0, hit1;
  int checks = 0;
  int fails = 0;
  logic hist0 [$];
  logic hist1 [$];

  localparam logic [3:0] PA = 4'b1011;
  localparam logic [6:0] PB = 7'b1010011;

  always #5 clk = ~clk;

  bitseq_spotter u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .hit(hit0));
  bitseq_spotter #(.PAT_LEN(7), .PATTERN(7'b1010011)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .hit(hit1));

  function automatic logic ends_with(logic q [$], logic [6:0] p, int len, logic b);
    int n;
    n = q.size() + 1;
    if (n < len) return 1'b0;
    for (int i = 0; i < len; i++) begin
      if (((n - len + i) < q.size() ? q[n - len + i] : b) != p[len - 1 - i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // drive one cycle, compare both instances against the model, update the model
  task automatic step(logic r, logic v, logic b, string tag, int want0 = -1);
    logic e0, e1;
    @(negedge clk);
    rst_n = r; in_valid = v; in_bit = b;
    #1;
    e0 = r && v && ends_with(hist0, {3'b000, PA}, 4, b);
    e1 = r && v && ends_with(hist1, PB, 7, b);
    check({tag, " u0"}, hit0, e0);
    check({tag, " u1"}, hit1, e1);
    if (want0 >= 0) check({tag, " directed"}, hit0, want0[0]);
    if (!r) begin hist0.delete(); hist1.delete(); end
    else if (v) begin
      if (e0) hist0.delete(); else hist0.push_back(b);
      if (e1) hist1.delete(); else hist1.push_back(b);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R6: reset state, hit low under reset even with a matching-looking bit
    step(0, 1, 1, "R6 reset", 0);
    step(0, 1, 1, "R6 reset", 0);
    // R1: plain 1011, single-cycle hit
    step(1, 1, 1, "R1"); step(1, 1, 0, "R1"); step(1, 1, 1, "R1");
    step(1, 1, 1, "R1 last bit", 1);
    step(1, 1, 1, "R1 one cycle", 0);
    step(0, 0, 0, "R6");
    // R3: 1011011 -> one hit only
    step(1, 1, 1, "R3"); step(1, 1, 0, "R3"); step(1, 1, 1, "R3");
    step(1, 1, 1, "R3 first", 1);
    step(1, 1, 0, "R3"); step(1, 1, 1, "R3");
    step(1, 1, 1, "R3 no overlap", 0);
    step(0, 0, 0, "R6");
    // R4/R5: gaps inside the pattern, with junk on in_bit
    step(1, 1, 1, "R4"); step(1, 0, 1, "R5 gap", 0); step(1, 1, 0, "R4");
    step(1, 0, 0, "R5 gap", 0); step(1, 0, 1, "R5 gap", 0); step(1, 1, 1, "R4");
    step(1, 0, 1, "R5 gap", 0);
    step(1, 1, 1, "R4 hit after gaps", 1);
    step(0, 0, 0, "R6");
    // R6: partial match dropped by reset
    step(1, 1, 1, "R6"); step(1, 1, 0, "R6"); step(1, 1, 1, "R6");
    step(0, 1, 1, "R6 mid reset", 0);
    step(1, 1, 1, "R6 after reset", 0);
    step(0, 0, 0, "R6");
    // R7: 101011 fallback
    step(1, 1, 1, "R7"); step(1, 1, 0, "R7"); step(1, 1, 1, "R7");
    step(1, 1, 0, "R7"); step(1, 1, 1, "R7");
    step(1, 1, 1, "R7 fallback hit", 1);
    step(0, 0, 0, "R6");
    // R2: 1010011 on the wide instance, twice back to back
    for (int rep = 0; rep < 2; rep++)
      for (int i = 6; i >= 0; i--) step(1, 1, PB[i], "R2 seven-bit pattern");
    // R8: random streams with injected back-to-back occurrences
    for (int it = 0; it < 1500; it++) begin
      int sel;
      sel = int'($urandom_range(0, 5));
      if (sel == 0) begin
        for (int rep = 0; rep < 2; rep++)
          for (int i = 3; i >= 0; i--) step(1, 1, PA[i], "R8 injected");
      end else if (sel == 1) begin
        for (int rep = 0; rep < 2; rep++)
          for (int i = 6; i >= 0; i--) step(1, ($urandom_range(0, 4) != 0), PB[i], "R8 injected");
      end else begin
        for (int i = 0; i < 8; i++)
          step(($urandom_range(0, 200) != 0), ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), "R8 random");
      end
    end
    finish_run();
  end
endmodule